// File: doc/BRIEF.md
# I2C Slave Address Recognition Unit

This block listens to a two-wire serial bus as a slave. Both bus lines are resynchronised to the system clock. The block then looks for START and STOP conditions and assembles the byte that follows each START or repeated START. It compares that byte with a programmable 8-bit configuration word. The upper seven bits of the word are the slave address. Bit 0 is a read/write-compare control, called the RW-compare bit below. The block reports the result on an addressed flag, a general-call flag and a one-cycle interrupt pulse. When acknowledge is enabled, it pulls SDA low for the ninth clock of a byte it accepts.

For ten-bit addressing, the block does not judge the second address byte. It hands that byte to software over a valid/ready output. Software checks it, then sets the RW-compare bit. The byte that follows the next repeated START must then equal the whole configuration word, including its R/W bit.

The output follows these back-pressure rules. `sb_data` stays stable while `sb_valid` is high and `sb_ready` is low. A handshake lowers `sb_valid` on the next cycle. A new captured byte always replaces the held one. If a capture and a handshake fall in the same cycle, the new byte is loaded and `sb_valid` stays high. Data-phase bytes, master operation and clock generation are outside this block.

Top module: `i2c_addr_match`

## Requirements
- R1: General call. When bits 7..1 of the received byte are all zero, `gen_call` and `aas` both become 1 and `irq` pulses once. This holds whatever bit 0 is and whatever the configuration word is.
- R2: Address match. Bytes arrive MSB first, sampled on SCL rising edges, and bit 0 is R/W. With `slv_cfg[0]`=0, a byte whose bits 7..1 equal `slv_cfg[7:1]` sets `aas`=1 and `gen_call`=0. It also raises `irq` for exactly one clock.
- R3: Any other address byte clears both `aas` and `gen_call` and raises no `irq`.
- R4: With `slv_cfg[0]`=1, a match needs all eight received bits, R/W included, to equal `slv_cfg[7:0]`.
- R5: Only the first byte after a START or repeated START is compared. Later bytes leave `aas`, `gen_call` and `irq` unchanged and are not acknowledged.
- R6: A STOP condition (SDA rising while SCL is high) clears `aas` and `gen_call`.
- R7: With `ack_en`=1 and the byte accepted, `sda_low` is 1 while SCL is high in the ninth clock. With `ack_en`=0, or with the byte rejected, `sda_low` stays 0.
- R8: With `ten_bit`=1, the second byte is captured without any compare and presented on `sb_data` with `sb_valid`=1. This happens when the first byte matches with its R/W bit 0, `slv_cfg[0]`=0 and no general call. The second byte is acknowledged under the rule of R7.
- R9: `sb_data` is held stable while `sb_valid`=1 and `sb_ready`=0. A handshake drops `sb_valid` on the next cycle. A capture replaces a held byte, and a capture in the same cycle as a handshake leaves `sb_valid`=1 with the new byte.
- R10: After reset, `aas`, `gen_call`, `irq`, `sda_low` and `sb_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_low | output | 1 | 1 = pull SDA low (acknowledge) |
| slv_cfg | input | ADDR_W+1 | Slave address in [7:1]; [0] is the RW-compare bit |
| ack_en | input | 1 | 1 = acknowledge accepted bytes |
| ten_bit | input | 1 | 1 = capture the second address byte for software |
| aas | output | 1 | Addressed as slave |
| gen_call | output | 1 | General call received |
| irq | output | 1 | One-cycle pulse on an accepted address |
| sb_data | output | ADDR_W+1 | Captured second address byte |
| sb_valid | output | 1 | `sb_data` holds an unconsumed byte |
| sb_ready | input | 1 | Consumer takes the byte |

## Verification
Two functions can land on the same clock edge: loading a freshly captured second address byte, and the consumer's handshake on the byte already held. The bench first leaves one captured byte unconsumed. It then sends a second ten-bit sequence and raises `sb_ready` for exactly the cycle in which the eighth bit of the new second byte is registered. It counts the synchroniser stages to find that cycle. The outcome is judged at the ports: `sb_valid` must still be 1 and `sb_data` must hold the new byte. If the handshake wrongly took priority, the valid flag would drop.

// File: rtl/iam_pkg.sv
package iam_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_ACK_A  = 3'd2,
    ST_SECOND = 3'd3,
    ST_ACK_S  = 3'd4,
    ST_PASS   = 3'd5
  } iam_state_e;

  typedef struct packed {
    logic gen_hit;
    logic own_hit;
  } cmp_res_t;

endpackage

// File: rtl/iam_line_sync.sv
module iam_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sr;
  logic [STAGES-1:0] sda_sr;
  logic              scl_d;
  logic              sda_d;
  logic              scl_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_in};
      sda_sr <= {sda_sr[STAGES-2:0], sda_in};
      scl_d  <= scl_sr[STAGES-1];
      sda_d  <= sda_sr[STAGES-1];
    end
  end

  assign scl_hi    = scl_sr[STAGES-1];
  assign sda_lvl   = sda_sr[STAGES-1];
  assign scl_rise  = scl_hi & ~scl_d;
  assign scl_fall  = ~scl_hi & scl_d;
  assign start_det = scl_hi & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_hi & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/iam_shift.sv
module iam_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] byte_next,
  output logic         last_bit
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  byte_q;
  logic [CW-1:0] cnt;

  assign byte_next = {byte_q[W-2:0], bit_in};
  assign last_bit  = shift_en && (cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      cnt    <= '0;
    end else if (clear) begin
      cnt    <= '0;
    end else if (shift_en) begin
      byte_q <= byte_next;
      cnt    <= last_bit ? '0 : cnt + CW'(1);
    end
  end

  // bit counter never passes the last bit position of a byte
  AST_CNT_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(W)); // R5

endmodule

// File: rtl/iam_addr_cmp.sv
module iam_addr_cmp #(
  parameter int AW = 7
) (
  input  logic              [AW:0] rx_byte,
  input  logic              [AW:0] own_cfg,
  output iam_pkg::cmp_res_t        res
);

  logic rbw;
  assign rbw = own_cfg[0];

  always_comb begin
    res.gen_hit = (rx_byte[AW:1] == '0);
    if (rbw) res.own_hit = (rx_byte == own_cfg);
    else     res.own_hit = (rx_byte[AW:1] == own_cfg[AW:1]);
  end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_low,
  input  logic [ADDR_W:0] slv_cfg,
  input  logic            ack_en,
  input  logic            ten_bit,
  output logic            aas,
  output logic            gen_call,
  output logic            irq,
  output logic [ADDR_W:0] sb_data,
  output logic            sb_valid,
  input  logic            sb_ready
);
  import iam_pkg::*;

  localparam int BW = ADDR_W + 1;

  logic          scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  logic          shift_en, last_bit, cap;
  logic [BW-1:0] byte_next;
  cmp_res_t      cmp;
  iam_state_e    st;
  logic          ack_q, ack_pend, ack_seen, want2, hit;

  iam_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign shift_en = scl_rise && (st == ST_ADDR || st == ST_SECOND);

  iam_shift #(.W(BW)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(start_det | stop_det),
    .shift_en(shift_en), .bit_in(sda_lvl),
    .byte_next(byte_next), .last_bit(last_bit)
  );

  iam_addr_cmp #(.AW(ADDR_W)) u_cmp (
    .rx_byte(byte_next), .own_cfg(slv_cfg), .res(cmp)
  );

  assign hit = cmp.gen_hit | cmp.own_hit;
  assign cap = (st == ST_SECOND) && last_bit && !start_det && !stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      aas      <= 1'b0;
      gen_call <= 1'b0;
      irq      <= 1'b0;
      ack_q    <= 1'b0;
      ack_pend <= 1'b0;
      ack_seen <= 1'b0;
      want2    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (start_det) begin
        st       <= ST_ADDR;
        ack_q    <= 1'b0;
        ack_seen <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        aas      <= 1'b0;
        gen_call <= 1'b0;
        ack_q    <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: if (last_bit) begin
            aas      <= hit;
            gen_call <= cmp.gen_hit;
            irq      <= hit;
            ack_pend <= hit;
            want2    <= ten_bit && cmp.own_hit && !cmp.gen_hit &&
                        !slv_cfg[0] && !byte_next[0];
            ack_seen <= 1'b0;
            st       <= ST_ACK_A;
          end
          ST_SECOND: if (last_bit) begin
            ack_pend <= 1'b1;
            ack_seen <= 1'b0;
            st       <= ST_ACK_S;
          end
          ST_ACK_A, ST_ACK_S: begin
            if (scl_rise) ack_seen <= 1'b1;
            if (scl_fall) begin
              if (!ack_seen) begin
                ack_q <= ack_pend && ack_en;
              end else begin
                ack_q <= 1'b0;
                st    <= (st == ST_ACK_A && want2) ? ST_SECOND : ST_PASS;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_low = ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_data  <= '0;
      sb_valid <= 1'b0;
    end else if (cap) begin
      sb_data  <= byte_next;
      sb_valid <= 1'b1;
    end else if (sb_valid && sb_ready) begin
      sb_valid <= 1'b0;
    end
  end

  AST_GC_SETS_AAS: assert property (@(posedge clk) disable iff (!rst_n)
    gen_call |-> aas); // R1
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R2
  AST_IRQ_WITH_AAS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> aas); // R2
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!aas && !gen_call)); // R6
  AST_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> $past(ack_en)); // R7
  AST_SB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_valid && !sb_ready && !cap) |=> (sb_valid && $stable(sb_data))); // R9

endmodule

// File: tb/sim_i2c_addr_match.sv
`timescale 1ns/1ps
module sim_i2c_addr_match;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       bsda = 1'b1;
  logic       sda_line;
  logic       sda_low;
  logic [7:0] slv_cfg = 8'h54;
  logic       ack_en = 1'b1;
  logic       ten_bit = 1'b0;
  logic       aas, gen_call, irq, sb_valid;
  logic [7:0] sb_data;
  logic       sb_ready = 1'b0;
  int         n_tests = 0;
  int         n_fail = 0;
  int         irq_cnt = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = bsda & ~sda_low;

  i2c_addr_match u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_low(sda_low), .slv_cfg(slv_cfg), .ack_en(ack_en), .ten_bit(ten_bit),
    .aas(aas), .gen_call(gen_call), .irq(irq),
    .sb_data(sb_data), .sb_valid(sb_valid), .sb_ready(sb_ready)
  );

  always @(posedge clk) if (rst_n && irq) irq_cnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw();
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_start();
    bsda = 1'b0; hw();
    scl = 1'b0;  hw();
  endtask

  task automatic bus_restart();
    bsda = 1'b1; hw();
    scl = 1'b1;  hw();
    bsda = 1'b0; hw();
    scl = 1'b0;  hw();
  endtask

  task automatic bus_stop();
    bsda = 1'b0; hw();
    scl = 1'b1;  hw();
    bsda = 1'b1; hw();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit hit_ready, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      bsda = b[i]; hw();
      scl = 1'b1;
      if (hit_ready && i == 0) begin
        repeat (2) @(negedge clk);
        sb_ready = 1'b1;
        @(negedge clk);
        sb_ready = 1'b0;
        repeat (2) @(negedge clk);
      end else begin
        hw();
      end
      scl = 1'b0; hw();
    end
    bsda = 1'b1; hw();
    scl = 1'b1;  hw();
    acked = (sda_line == 1'b0);
    scl = 1'b0;  hw();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    bit ack;
    int c0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!aas && !gen_call && !irq && !sda_low && !sb_valid, "R10 reset",
        {aas, gen_call, irq, sda_low, sb_valid}, 0);

    // sweep all first bytes, RW-compare off
    slv_cfg = 8'h54;
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb;
      bit g, e;
      string tg;
      bb = 8'(b);
      g  = (bb[7:1] == 7'h00);
      e  = g || (bb[7:1] == 7'h2A);
      tg = g ? "R1" : (e ? "R2" : "R3");
      c0 = irq_cnt;
      bus_start();
      send_byte(bb, 1'b0, ack);
      chk(aas == e, tg, aas, e);
      chk(gen_call == g, tg, gen_call, g);
      chk((irq_cnt - c0) == int'(e), tg, irq_cnt - c0, e);
      chk(ack == e, "R7 ack", ack, e);
      bus_stop();
      chk(!aas && !gen_call, "R6 stop", {aas, gen_call}, 0);
    end

    // sweep with RW-compare on: whole byte must match
    slv_cfg = 8'h55;
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb;
      bit g, e;
      bb = 8'(b);
      g  = (bb[7:1] == 7'h00);
      e  = g || (bb == 8'h55);
      c0 = irq_cnt;
      bus_start();
      send_byte(bb, 1'b0, ack);
      chk(aas == e, "R4 match", aas, e);
      chk((irq_cnt - c0) == int'(e), "R4 irq", irq_cnt - c0, e);
      chk(ack == e, "R7 ack", ack, e);
      bus_stop();
    end

    // R5 data bytes not compared
    slv_cfg = 8'h54;
    c0 = irq_cnt;
    bus_start();
    send_byte(8'h54, 1'b0, ack);
    send_byte(8'h00, 1'b0, ack);
    chk(aas && !gen_call, "R5 data byte", {aas, gen_call}, 2);
    chk(!ack, "R5 no ack on data", ack, 0);
    send_byte(8'h31, 1'b0, ack);
    chk(aas, "R5 flag kept", aas, 1);
    chk((irq_cnt - c0) == 1, "R5 irq count", irq_cnt - c0, 1);
    bus_restart();
    send_byte(8'h31, 1'b0, ack);
    chk(!aas, "R5 restart recompares", aas, 0);
    bus_stop();

    // R7 acknowledge disabled
    ack_en = 1'b0;
    bus_start();
    send_byte(8'h55, 1'b0, ack);
    chk(aas && !ack, "R7 ack disabled", {aas, ack}, 2);
    bus_stop();
    ack_en = 1'b1;

    // R8 ten-bit sequence
    ten_bit = 1'b1;
    slv_cfg = 8'hF0;
    bus_start();
    send_byte(8'hF0, 1'b0, ack);
    chk(aas && ack, "R8 first byte", {aas, ack}, 3);
    send_byte(8'h3C, 1'b0, ack);
    chk(ack, "R8 second ack", ack, 1);
    chk(sb_valid && sb_data == 8'h3C, "R8 capture", sb_data, 8'h3C);
    slv_cfg = 8'hF1;
    c0 = irq_cnt;
    bus_restart();
    send_byte(8'hF1, 1'b0, ack);
    chk(aas && ack && (irq_cnt - c0) == 1, "R8 rematch", irq_cnt - c0, 1);
    bus_restart();
    send_byte(8'hF0, 1'b0, ack);
    chk(!aas, "R4 rw mismatch", aas, 0);
    bus_stop();

    // R9 hold, overwrite, same-cycle capture and handshake
    chk(sb_valid && sb_data == 8'h3C, "R9 hold", sb_data, 8'h3C);
    slv_cfg = 8'hF0;
    bus_start();
    send_byte(8'hF0, 1'b0, ack);
    send_byte(8'hA5, 1'b0, ack);
    chk(sb_valid && sb_data == 8'hA5, "R9 overwrite", sb_data, 8'hA5);
    bus_restart();
    send_byte(8'hF0, 1'b0, ack);
    send_byte(8'h5A, 1'b1, ack);
    chk(sb_valid, "R9 same-cycle valid", sb_valid, 1);
    chk(sb_data == 8'h5A, "R9 same-cycle data", sb_data, 8'h5A);
    bus_stop();
    sb_ready = 1'b1;
    @(negedge clk);
    sb_ready = 1'b0;
    @(negedge clk);
    chk(!sb_valid, "R9 handshake", sb_valid, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule